// File: doc/BRIEF.md
# Minimal UART with Five-Byte Receive Queue

This block is a compact serial port with two bus addresses. Address 0 holds the control and status byte. Address 1 reads the oldest received byte and writes the next byte to send. Framing is fixed at one start bit, eight data bits sent least significant bit first, no parity and one stop bit. A 3-bit mode field picks one of seven bit rates. The eighth mode code switches the port off.

Received bytes wait in a five-entry queue. Bytes to send pass through a single holding register in front of the shifter. One interrupt line combines two causes. It stays high while received data is waiting. It is also set when the holding register empties, and that cause stays set until software reads the status byte. A status read also clears the overrun flag. The bit rate comes from a 16x oversampling tick. At mode 0 the tick period is `BASE_CLKS` system clocks, and the other modes multiply it by 2, 3, 6, 12, 24 or 48.

Top module: `mini_uart`

## Requirements
- R1: After reset, status (address 0) reads 0x01 with CTS low. `irq_o` is low, `tx_o` is high and `rts_o` is low.
- R2: A write to address 1 sends one frame on `tx_o`: a low start bit, 8 data bits least significant bit first, then a high stop bit. The line idles high and each bit lasts `BASE_CLKS`*16*divisor clocks.
- R3: Status bits 7:5 hold the mode. Writes to address 0 set it from `wdata_i[7:5]`. Modes 0 to 6 use divisors 1, 2, 3, 6, 12, 24 and 48.
- R4: A frame is detected only on a falling edge of `rx_i`. Each bit is sampled at its middle. A low pulse that has ended by the middle of the start bit is rejected. A read of address 1 returns the received byte.
- R5: A frame whose stop bit is low is discarded, and the next good frame is received normally.
- R6: Up to 5 received bytes are queued and read back oldest first. Status bit 1 is high while the queue holds data.
- R7: A byte that arrives while the queue is full is dropped and sets status bit 2. A status read clears bit 2.
- R8: The transmit holding register holds one byte, and status bit 0 is high while it is empty. A write to address 1 while it is full is ignored.
- R9: Status bit 3 follows `cts_i` after a two-flop synchronizer. Status bit 4 is written from `wdata_i[4]` at address 0 and drives `rts_o`.
- R10: `irq_o` is high while the receive queue holds data.
- R11: When status bit 0 rises, `irq_o` is set. It stays set until the next status read.
- R12: In mode 7, `irq_o` is low, `tx_o` stays high and incoming frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe, one cycle |
| wr_i | input | 1 | Write strobe, one cycle |
| addr_i | input | 1 | 0 = control/status, 1 = data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| rx_i | input | 1 | Serial input |
| tx_o | output | 1 | Serial output |
| cts_i | input | 1 | Clear-to-send input |
| rts_o | output | 1 | Request-to-send output |
| irq_o | output | 1 | Interrupt, level |

## Verification
Frames are sent through the receiver with several byte values:
- alternating and mixed bit patterns, which expose bit-order and sampling-phase errors;
- a burst of six back-to-back frames, which separates correct queue ordering from an overrun that overwrites the newest entry;
- a frame with a low stop bit, and a short low pulse, which show whether the receiver filters its input or accepts anything;
- frames at three different modes, which catch a wrong divisor that a single rate would hide.

On the transmit side, three writes are issued close together. The bench checks that the second write is held in the holding register and the third is dropped.

// File: rtl/mini_uart_pkg.sv
package mini_uart_pkg;
  localparam int unsigned OVS = 16;
  localparam logic [2:0] MODE_OFF = 3'd7;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  function automatic int unsigned mode_div(input logic [2:0] m);
    case (m)
      3'd0: mode_div = 1;
      3'd1: mode_div = 2;
      3'd2: mode_div = 3;
      3'd3: mode_div = 6;
      3'd4: mode_div = 12;
      3'd5: mode_div = 24;
      default: mode_div = 48;
    endcase
  endfunction
endpackage

// File: rtl/mini_uart_baud.sv
module mini_uart_baud #(
  parameter int unsigned BASE_CLKS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] mode_i,
  output logic       tick_o
);
  import mini_uart_pkg::*;
  localparam int unsigned CW = $clog2(BASE_CLKS * 48 + 1);

  logic [CW-1:0] cnt_q, lim;

  always_comb lim = CW'(BASE_CLKS * mode_div(mode_i) - 1);
  assign tick_o = en_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!en_i)        cnt_q <= '0;
    else if (cnt_q >= lim) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mini_uart_rx.sv
module mini_uart_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       tick_i,
  input  logic       rx_i,
  output logic       valid_o,
  output logic [7:0] data_o
);
  import mini_uart_pkg::*;

  rx_state_e  st_q;
  logic [3:0] tcnt_q;
  logic [2:0] bcnt_q;
  logic [7:0] sh_q;
  logic       prev_q, valid_q;

  assign valid_o = valid_q;
  assign data_o  = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= RX_IDLE; tcnt_q <= '0; bcnt_q <= '0; sh_q <= '0;
      prev_q <= 1'b1; valid_q <= 1'b0;
    end else if (clr_i) begin
      st_q <= RX_IDLE; tcnt_q <= '0; bcnt_q <= '0;
      prev_q <= 1'b1; valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (tick_i) begin
        prev_q <= rx_i;
        unique case (st_q)
          RX_IDLE: if (prev_q && !rx_i) begin
            st_q <= RX_START; tcnt_q <= '0;
          end
          RX_START: begin
            if (tcnt_q == 4'd7) begin
              tcnt_q <= '0; bcnt_q <= '0;
              st_q   <= rx_i ? RX_IDLE : RX_DATA;  // glitch reject at mid start
            end else tcnt_q <= tcnt_q + 1'b1;
          end
          RX_DATA: begin
            if (tcnt_q == 4'd15) begin
              tcnt_q <= '0;
              sh_q   <= {rx_i, sh_q[7:1]};
              if (bcnt_q == 3'd7) st_q <= RX_STOP;
              else bcnt_q <= bcnt_q + 1'b1;
            end else tcnt_q <= tcnt_q + 1'b1;
          end
          RX_STOP: begin
            if (tcnt_q == 4'd15) begin
              tcnt_q  <= '0;
              valid_q <= rx_i;
              st_q    <= RX_IDLE;
            end else tcnt_q <= tcnt_q + 1'b1;
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mini_uart_tx.sv
module mini_uart_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       tick_i,
  input  logic       wr_i,
  input  logic [7:0] din_i,
  output logic       empty_o,
  output logic       tx_o
);
  logic       full_q, busy_q, load;
  logic [7:0] hold_q;
  logic [9:0] sh_q;
  logic [3:0] tcnt_q, bidx_q;

  assign load    = !busy_q && full_q && !clr_i;
  assign empty_o = !full_q;
  assign tx_o    = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0; hold_q <= '0;
    end else if (load) begin
      full_q <= 1'b0;
    end else if (wr_i && !full_q) begin
      full_q <= 1'b1; hold_q <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; sh_q <= '1; tcnt_q <= '0; bidx_q <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0; tcnt_q <= '0; bidx_q <= '0;
    end else if (load) begin
      sh_q <= {1'b1, hold_q, 1'b0};
      busy_q <= 1'b1; tcnt_q <= '0; bidx_q <= '0;
    end else if (busy_q && tick_i) begin
      if (tcnt_q == 4'd15) begin
        tcnt_q <= '0;
        sh_q   <= {1'b1, sh_q[9:1]};
        if (bidx_q == 4'd9) busy_q <= 1'b0;
        else bidx_q <= bidx_q + 1'b1;
      end else tcnt_q <= tcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mini_uart_fifo.sv
module mini_uart_fifo #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned W     = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign dout_o  = mem_q[rp_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) if (do_push) mem_q[wp_q] <= din_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/mini_uart.sv
module mini_uart #(
  parameter int unsigned BASE_CLKS = 4,
  parameter int unsigned RX_DEPTH  = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       rx_i,
  output logic       tx_o,
  input  logic       cts_i,
  output logic       rts_o,
  output logic       irq_o
);
  import mini_uart_pkg::*;
  localparam int unsigned CW = $clog2(RX_DEPTH + 1);

  logic [2:0]    mode_q;
  logic          rts_q, ovf_q, pend_q, tbre_d_q;
  logic [1:0]    rx_sync_q, cts_sync_q;
  logic          off, tick, rx_valid, tbre, stat_rd;
  logic [7:0]    rx_byte, fifo_dout;
  logic [CW-1:0] fifo_cnt;
  logic          fifo_full, fifo_empty;

  assign off     = (mode_q == MODE_OFF);
  assign stat_rd = rd_i && !addr_i;

  mini_uart_baud #(.BASE_CLKS(BASE_CLKS)) u_baud (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(!off), .mode_i(mode_q), .tick_o(tick)
  );

  mini_uart_rx u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(off), .tick_i(tick),
    .rx_i(rx_sync_q[1]), .valid_o(rx_valid), .data_o(rx_byte)
  );

  mini_uart_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(rx_valid), .din_i(rx_byte),
    .pop_i(rd_i && addr_i), .dout_o(fifo_dout), .count_o(fifo_cnt),
    .full_o(fifo_full), .empty_o(fifo_empty)
  );

  mini_uart_tx u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(off), .tick_i(tick),
    .wr_i(wr_i && addr_i), .din_i(wdata_i), .empty_o(tbre), .tx_o(tx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0; rts_q <= 1'b0; ovf_q <= 1'b0; pend_q <= 1'b0;
      tbre_d_q <= 1'b1; rx_sync_q <= 2'b11; cts_sync_q <= 2'b00;
    end else begin
      rx_sync_q  <= {rx_sync_q[0], rx_i};
      cts_sync_q <= {cts_sync_q[0], cts_i};
      tbre_d_q   <= tbre;
      if (wr_i && !addr_i) begin
        mode_q <= wdata_i[7:5];
        rts_q  <= wdata_i[4];
      end
      if (rx_valid && fifo_full) ovf_q <= 1'b1;
      else if (stat_rd)          ovf_q <= 1'b0;
      if (tbre && !tbre_d_q)     pend_q <= 1'b1;
      else if (stat_rd)          pend_q <= 1'b0;
    end
  end

  assign rts_o   = rts_q;
  assign irq_o   = !off && (!fifo_empty || pend_q);
  assign rdata_o = addr_i ? fifo_dout
                          : {mode_q, rts_q, cts_sync_q[1], ovf_q, !fifo_empty, tbre};
endmodule

// File: rtl/mini_uart_chk.sv
module mini_uart_chk #(
  parameter int unsigned DEPTH = 5,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_i,
  input logic          addr_i,
  input logic          tx_o,
  input logic          irq_o,
  input logic [2:0]    mode_q,
  input logic [CW-1:0] fifo_cnt,
  input logic          fifo_empty,
  input logic          rx_valid,
  input logic          ovf_q
);
  p_off_no_irq_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd7) |-> !irq_o);

  p_off_tx_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd7 && $past(mode_q) == 3'd7) |-> tx_o);

  p_fifo_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH));

  p_pop_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i && fifo_cnt != '0 && !rx_valid) |=> fifo_cnt == $past(fifo_cnt) - 1'b1);

  p_ovf_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid && fifo_cnt == CW'(DEPTH)) |=> ovf_q);

  p_ovf_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !addr_i && !(rx_valid && fifo_cnt == CW'(DEPTH))) |=> !ovf_q);

  p_rx_level_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != 3'd7 && !fifo_empty) |-> irq_o);
endmodule

bind mini_uart mini_uart_chk #(.DEPTH(RX_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .addr_i(addr_i), .tx_o(tx_o),
  .irq_o(irq_o), .mode_q(mode_q), .fifo_cnt(fifo_cnt), .fifo_empty(fifo_empty),
  .rx_valid(rx_valid), .ovf_q(ovf_q)
);

// File: tb/mini_uart_tb.sv
module mini_uart_tb;
  localparam int BASE = 4;
  localparam int BP0  = BASE * 16;

  logic clk = 0, rst_ni = 0, rd_i = 0, wr_i = 0, addr_i = 0;
  logic [7:0] wdata_i = 0, rdata_o;
  logic rx_i = 1, tx_o, cts_i = 0, rts_o, irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [7:0] mq[$];
  bit m_ovf = 0, m_pend = 0, m_rts = 0, chk_en = 0;
  logic [2:0] m_mode = 0;

  always #5 clk = ~clk;

  mini_uart #(.BASE_CLKS(BASE), .RX_DEPTH(5)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rx_i(rx_i), .tx_o(tx_o),
    .cts_i(cts_i), .rts_o(rts_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model (CTS bit masked)
  always @(negedge clk) begin
    if (chk_en && rst_ni && !rd_i && !wr_i && !addr_i) begin
      logic [7:0] e;
      bit ei;
      e  = {m_mode, m_rts, 1'b0, m_ovf, mq.size() != 0, 1'b1};
      ei = (m_mode != 3'd7) && (mq.size() != 0 || m_pend);
      chk((rdata_o & 8'hF7) == e, "R6/R7 model status", rdata_o & 8'hF7, e);
      chk(irq_o == ei, "R10/R11 model irq", irq_o, ei);
    end
  end

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr_i = a; rd_i = 1; #1 d = rdata_o;
    @(posedge clk);
    if (!a) begin m_ovf = 0; m_pend = 0; end
    else if (mq.size() > 0) void'(mq.pop_front());
    #1 rd_i = 0; addr_i = 0;
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr_i = a; wr_i = 1; wdata_i = d;
    @(posedge clk);
    if (!a) begin m_mode = d[7:5]; m_rts = d[4]; end
    #1 wr_i = 0; addr_i = 0;
  endtask

  task automatic send(input logic [7:0] d, input bit stop_ok, input int bp);
    chk_en = 0;
    @(negedge clk); rx_i = 0; repeat (bp) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx_i = d[i]; repeat (bp) @(negedge clk); end
    rx_i = stop_ok; repeat (bp) @(negedge clk);
    rx_i = 1; repeat (bp) @(negedge clk);
    if (stop_ok && m_mode != 3'd7) begin
      if (mq.size() < 5) mq.push_back(d); else m_ovf = 1;
    end
    chk_en = 1;
  endtask

  task automatic decode(input int bp, output logic [7:0] d, output bit ok);
    @(negedge tx_o);
    repeat (bp / 2) @(negedge clk);
    ok = (tx_o == 1'b0);
    for (int i = 0; i < 8; i++) begin repeat (bp) @(negedge clk); d[i] = tx_o; end
    repeat (bp) @(negedge clk);
    ok = ok && (tx_o == 1'b1);
  endtask

  task automatic tx_one(input logic [7:0] v, input int bp, input string req);
    logic [7:0] got; bit ok;
    chk_en = 0;
    fork
      bus_wr(1'b1, v);
      decode(bp, got, ok);
    join
    chk(got == v, req, got, v);
    chk(ok, {req, " framing"}, ok, 1);
    m_pend = 1;
    chk_en = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] got_a, got_b;
    bit ok_a, ok_b, extra;

    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1;
    #1;
    // R1 reset state
    chk(rdata_o == 8'h01, "R1 status", rdata_o, 8'h01);
    chk(irq_o == 0, "R1 irq", irq_o, 0);
    chk(tx_o == 1, "R1 tx idle", tx_o, 1);
    chk(rts_o == 0, "R1 rts", rts_o, 0);
    chk_en = 1;

    // R9 RTS and CTS
    bus_wr(1'b0, 8'h10);
    #1 chk(rts_o == 1, "R9 rts_o", rts_o, 1);
    cts_i = 1; repeat (3) @(negedge clk);
    bus_rd(1'b0, d);
    chk(d[3] == 1, "R9 cts bit", d[3], 1);
    chk(d[4] == 1, "R9 rts bit", d[4], 1);
    cts_i = 0; repeat (3) @(negedge clk);
    bus_rd(1'b0, d);
    chk(d[3] == 0, "R9 cts low", d[3], 0);

    // R2 transmit, R11 edge interrupt
    tx_one(8'hA5, BP0, "R2 tx byte");
    repeat (BP0) @(negedge clk);
    chk(irq_o == 1, "R11 irq after TBRE rise", irq_o, 1);
    bus_rd(1'b0, d);
    #1 chk(irq_o == 0, "R11 irq cleared by status read", irq_o, 0);

    // R4 receive, R10 level interrupt
    send(8'h3C, 1, BP0);
    chk(irq_o == 1, "R10 irq with rx data", irq_o, 1);
    bus_rd(1'b0, d);
    chk(d[1] == 1, "R6 DR set", d[1], 1);
    #1 chk(irq_o == 1, "R10 irq held by data", irq_o, 1);
    bus_rd(1'b1, d);
    chk(d == 8'h3C, "R4 rx byte", d, 8'h3C);
    #1 chk(irq_o == 0, "R10 irq drop when empty", irq_o, 0);

    // R6 queue order
    for (int i = 0; i < 5; i++) send(8'h11 * (i + 1), 1, BP0);
    for (int i = 0; i < 5; i++) begin
      bus_rd(1'b1, d);
      chk(d == 8'(8'h11 * (i + 1)), "R6 fifo order", d, 8'h11 * (i + 1));
    end

    // R7 overflow
    for (int i = 0; i < 6; i++) send(8'hC0 + 8'(i), 1, BP0);
    bus_rd(1'b0, d);
    chk(d[2] == 1, "R7 overflow flag", d[2], 1);
    bus_rd(1'b0, d);
    chk(d[2] == 0, "R7 flag cleared", d[2], 0);
    for (int i = 0; i < 5; i++) begin
      bus_rd(1'b1, d);
      chk(d == 8'hC0 + 8'(i), "R7 sixth byte dropped", d, 8'hC0 + i);
    end
    bus_rd(1'b0, d);
    chk(d[1] == 0, "R7 fifo empty after drain", d[1], 0);

    // R5 bad stop
    send(8'h77, 0, BP0);
    bus_rd(1'b0, d);
    chk(d[1] == 0, "R5 bad stop discarded", d[1], 0);
    send(8'h12, 1, BP0);
    bus_rd(1'b1, d);
    chk(d == 8'h12, "R5 recovery", d, 8'h12);

    // R4 glitch rejection
    chk_en = 0;
    @(negedge clk); rx_i = 0; repeat (BASE * 4) @(negedge clk); rx_i = 1;
    repeat (2 * BP0) @(negedge clk);
    chk_en = 1;
    bus_rd(1'b0, d);
    chk(d[1] == 0, "R4 glitch rejected", d[1], 0);

    // R8 one-entry holding register, third write ignored
    chk_en = 0;
    extra = 0;
    fork
      begin
        bus_wr(1'b1, 8'h5A);
        repeat (2) @(negedge clk);
        bus_wr(1'b1, 8'hE1);
        #1 chk(rdata_o[0] == 0, "R8 TBRE low while held", rdata_o[0], 0);
        bus_wr(1'b1, 8'h0F);
      end
      begin
        decode(BP0, got_a, ok_a);
        decode(BP0, got_b, ok_b);
      end
    join
    chk(got_a == 8'h5A, "R8 first byte", got_a, 8'h5A);
    chk(got_b == 8'hE1, "R8 held byte", got_b, 8'hE1);
    for (int i = 0; i < 12 * BP0; i++) begin
      @(negedge clk);
      if (!tx_o) extra = 1;
    end
    chk(!extra, "R8 write while full ignored", extra, 0);
    m_pend = 1;
    chk_en = 1;
    bus_rd(1'b0, d);
    chk(d[0] == 1, "R8 TBRE set", d[0], 1);

    // R3 other rates
    bus_wr(1'b0, {3'd1, 1'b1, 4'b0});
    tx_one(8'h30, BP0 * 2, "R3 mode1 tx");
    send(8'hC3, 1, BP0 * 2);
    bus_rd(1'b1, d);
    chk(d == 8'hC3, "R3 mode1 rx", d, 8'hC3);
    bus_wr(1'b0, {3'd6, 1'b1, 4'b0});
    tx_one(8'h96, BP0 * 48, "R3 mode6 tx");

    // R12 off
    bus_wr(1'b0, {3'd7, 1'b1, 4'b0});
    #1 chk(irq_o == 0, "R12 irq off", irq_o, 0);
    extra = 0;
    fork
      send(8'h55, 1, BP0);
      for (int i = 0; i < 11 * BP0; i++) begin
        @(negedge clk);
        if (!tx_o) extra = 1;
      end
    join
    chk(!extra, "R12 tx idle", extra, 0);
    bus_wr(1'b0, {3'd0, 1'b1, 4'b0});
    bus_rd(1'b0, d);
    chk(d[1] == 0, "R12 rx ignored", d[1], 0);
    chk(d[7:5] == 3'd0, "R3 mode readback", d[7:5], 0);

    repeat (20) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule